// File: doc/BRIEF.md
# ATA PIO Cycle Timing Sequencer

This block carries out a single parallel-ATA programmed-I/O transfer in hardware. A request supplies a register select, a direction, a flag that marks the access as an 8-bit task-file register access or a 16-bit data-port access, and a write word. The block then drives the address lines, the two chip selects and the active-low read and write strobes through three phases:

- **Setup:** the address is presented with both strobes high.
- **Active:** one strobe is held low.
- **Recovery:** both strobes are high again.

It then pulses `done` and returns the captured read word.

Phase lengths come from a small set of timing registers. These registers reset to slow PIO mode 0 values and are reloaded from configuration inputs. Register accesses and data accesses each have their own active, cycle and minimum-recovery counts. An optional ready handshake stretches the active phase while the device holds its ready line low. The stretch is bounded, and a sticky flag reports when that bound is reached.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset, `bus_sel[1:0]` is 2'b11 (both chip selects high), `dior_n` and `diow_n` are high, and `busy`, `done` and `iordy_timeout` are low. `bus_sel` reads 5'b00011 whenever `busy` is low. The timing registers reset to the following values (in clock cycles), and the ready check is off:
  - setup 4;
  - register set: active 15, cycle 30, recovery 15;
  - data set: active 9, cycle 30, recovery 4.
- R2: `bus_sel` is packed as {A2,A1,A0,CS1N,CS0N}.
  - With `req_sel[3]`=0, a command-block register is addressed: A=`req_sel[2:0]`, CS1N=1, CS0N=0.
  - With `req_sel[3]`=1, the control register is addressed: A=6, CS1N=0, CS0N=1.
  - The select is held from the first cycle after acceptance until `done`.
  - Both strobes stay high for the first S cycles, where S = max(setup, 1).
- R3: A read (`req_write`=0) drives only `dior_n` low and a write drives only `diow_n` low. The two strobes are never low together.
- R4: `bus_dout_en` is high exactly while `diow_n` is low, and `bus_dout` then carries the request's write word.
- R5: On a read, `bus_din` is sampled at the clock edge where `dior_n` returns high. The sampled value appears on `rdata` when `done` is high.
- R6: `req_is_reg`=1 selects the register timing set and `req_is_reg`=0 selects the data timing set.
- R7: The active phase runs k+1 cycles.
  - A is max(active, 1).
  - With the ready check off, k = A-1 and `iordy` is ignored.
  - With the ready check on, k is the first active-cycle index j such that j ≥ A-1 and one of these holds:
    - j ≥ IORDY_SMP and `iordy` is high in cycle j;
    - j = IORDY_LIM-1.
- R8: Recovery lasts R cycles, using cycle count C and Rm = max(recovery, 1). R = C-(k+1) when C-(k+1) > Rm, and R = Rm otherwise.
- R9: A ready wait that ends at the IORDY_LIM-1 bound, without ready seen high, still completes normally. It sets `iordy_timeout`, which stays high until reset.
- R10: `busy` rises on the cycle after an accepted request and falls in the same cycle that `done` rises. `done` is high for one cycle. Requests presented while `busy` is high are ignored.
- R11: A timing count of zero acts as one cycle for setup, active and recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_is_reg | input | 1 | 1 = register timing set, 0 = data timing set |
| req_sel | input | 4 | Bit 3 selects the control block, bits 2:0 the register index |
| req_wdata | input | DATA_W | Write word |
| cfg_load | input | 1 | Load the timing registers from the cfg inputs |
| cfg_setup | input | 8 | Setup count |
| cfg_act8 | input | 8 | Register active count |
| cfg_cyc8 | input | 8 | Register cycle count |
| cfg_rec8 | input | 8 | Register minimum recovery count |
| cfg_act16 | input | 8 | Data active count |
| cfg_cyc16 | input | 8 | Data cycle count |
| cfg_rec16 | input | 8 | Data minimum recovery count |
| cfg_iordy_en | input | 1 | Enable the ready stretch |
| iordy | input | 1 | Device ready line (already synchronous) |
| bus_din | input | DATA_W | Data read from the bus |
| bus_sel | output | 5 | {A2,A1,A0,CS1N,CS0N} |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |
| bus_dout | output | DATA_W | Data driven to the bus |
| bus_dout_en | output | 1 | Drive enable for bus_dout |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read word |
| iordy_timeout | output | 1 | Sticky ready-wait timeout flag |

## Verification
The following times are counted in clock edges after the accepting edge t=0:
- the address appears at t=0;
- a strobe falls at t=S and rises at t=S+k+1;
- `done` and the read word arrive at t=S+k+1+R;
- the timeout flag is set one edge after the strobe rises, so it is visible by `done`.

The bench computes S, k and R for each request from the requirement formulas. It then compares every output on every falling edge against the values due at that t. It feeds the valid read word only in the last active cycle, so capture one edge early or late is detected. It asserts stray requests through a whole cycle to show they change nothing.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    parameter int CNT_W      = 8;
    parameter int SEL_W      = 4;
    parameter int BSEL_W     = 5;
    parameter int DATA_W_DEF = 16;

    // ready sample point and stretch bound in cycles (about 35 ns and 1285 ns at 50 MHz)
    parameter int IORDY_SMP_DEF = 2;
    parameter int IORDY_LIM_DEF = 65;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t act;
        cnt_t cyc;
        cnt_t rec;
    } tset_t;

    // slow mode 0 defaults in 20 ns cycles
    localparam cnt_t  DEF_SETUP = cnt_t'(4);
    localparam tset_t DEF_REG8  = '{act: cnt_t'(15), cyc: cnt_t'(30), rec: cnt_t'(15)};
    localparam tset_t DEF_DAT16 = '{act: cnt_t'(9),  cyc: cnt_t'(30), rec: cnt_t'(4)};

    localparam logic [BSEL_W-1:0] BSEL_IDLE = 5'b000_11;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOV
    } phase_e;

    function automatic cnt_t at_least_one(cnt_t v);
        return (v == '0) ? cnt_t'(1) : v;
    endfunction

    // {A2,A1,A0,CS1N,CS0N}
    function automatic logic [BSEL_W-1:0] map_sel(logic [SEL_W-1:0] sel);
        if (sel[SEL_W-1])
            return {3'd6, 1'b0, 1'b1};
        return {sel[2:0], 1'b1, 1'b0};
    endfunction

    // recovery = leftover cycle time when it beats the minimum, else the minimum
    function automatic cnt_t recov_len(cnt_t cyc, logic [CNT_W:0] act_eff, cnt_t rec);
        logic [CNT_W:0] left;
        cnt_t           rmin;
        rmin = at_least_one(rec);
        left = {1'b0, cyc} - act_eff;
        if (({1'b0, cyc} > act_eff) && (left > {1'b0, rmin}))
            return left[CNT_W-1:0];
        return rmin;
    endfunction

endpackage

// File: rtl/ata_pio_cfg_regs.sv
module ata_pio_cfg_regs
    import ata_pio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  cnt_t  setup_in,
    input  tset_t reg_in,
    input  tset_t dat_in,
    input  logic  en_in,
    input  logic  is_reg,
    output tset_t set_out,
    output cnt_t  setup_out,
    output logic  en_out
);

    tset_t reg_q;
    tset_t dat_q;
    cnt_t  setup_q;
    logic  en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q   <= DEF_REG8;
            dat_q   <= DEF_DAT16;
            setup_q <= DEF_SETUP;
            en_q    <= 1'b0;
        end else if (load) begin
            reg_q   <= reg_in;
            dat_q   <= dat_in;
            setup_q <= setup_in;
            en_q    <= en_in;
        end
    end

    assign set_out   = is_reg ? reg_q : dat_q;
    assign setup_out = setup_q;
    assign en_out    = en_q;

endmodule

// File: rtl/ata_pio_bus_map.sv
module ata_pio_bus_map
    import ata_pio_pkg::*;
(
    input  logic              active,
    input  logic [SEL_W-1:0]  sel,
    output logic [BSEL_W-1:0] bus_sel
);

    always_comb begin
        bus_sel = active ? map_sel(sel) : BSEL_IDLE;
    end

endmodule

// File: rtl/ata_pio_phase_ctl.sv
module ata_pio_phase_ctl
    import ata_pio_pkg::*;
#(
    parameter int IORDY_SMP = IORDY_SMP_DEF,
    parameter int IORDY_LIM = IORDY_LIM_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  is_write,
    input  tset_t set_in,
    input  cnt_t  setup_in,
    input  logic  en_in,
    input  logic  iordy,
    output logic  rd_n,
    output logic  wr_n,
    output logic  den,
    output logic  busy,
    output logic  done,
    output logic  capture,
    output logic  tmo_pulse
);

    localparam cnt_t SMP_C  = cnt_t'(IORDY_SMP);
    localparam cnt_t LIM_M1 = cnt_t'(IORDY_LIM - 1);

    phase_e ph;
    cnt_t   cnt;
    cnt_t   rlen;
    cnt_t   setup_q;
    tset_t  set_q;
    logic   wr_q;
    logic   en_q;

    logic [CNT_W:0] cnt_p1;
    logic           nominal_ok;
    logic           rdy_ok;
    logic           at_lim;
    logic           act_end;

    always_comb begin
        cnt_p1     = {1'b0, cnt} + 1'b1;
        nominal_ok = cnt_p1 >= {1'b0, at_least_one(set_q.act)};
        rdy_ok     = (cnt >= SMP_C) && iordy;
        at_lim     = cnt >= LIM_M1;
        act_end    = (ph == PH_ACTIVE) && nominal_ok && (!en_q || rdy_ok || at_lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            cnt       <= '0;
            rlen      <= '0;
            setup_q   <= '0;
            set_q     <= '0;
            wr_q      <= 1'b0;
            en_q      <= 1'b0;
            rd_n      <= 1'b1;
            wr_n      <= 1'b1;
            den       <= 1'b0;
            done      <= 1'b0;
            tmo_pulse <= 1'b0;
        end else begin
            done      <= 1'b0;
            tmo_pulse <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        setup_q <= setup_in;
                        set_q   <= set_in;
                        wr_q    <= is_write;
                        en_q    <= en_in;
                        cnt     <= '0;
                        ph      <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt_p1 >= {1'b0, at_least_one(setup_q)}) begin
                        cnt <= '0;
                        ph  <= PH_ACTIVE;
                        if (wr_q) begin
                            wr_n <= 1'b0;
                            den  <= 1'b1;
                        end else begin
                            rd_n <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_ACTIVE: begin
                    if (act_end) begin
                        rd_n      <= 1'b1;
                        wr_n      <= 1'b1;
                        den       <= 1'b0;
                        rlen      <= recov_len(set_q.cyc, cnt_p1, set_q.rec);
                        tmo_pulse <= en_q && !rdy_ok;
                        cnt       <= '0;
                        ph        <= PH_RECOV;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt_p1 >= {1'b0, rlen}) begin
                        cnt  <= '0;
                        done <= 1'b1;
                        ph   <= PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy    = (ph != PH_IDLE);
    assign capture = act_end && !wr_q;

    // R3: strobes never overlap
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> wr_n);

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: a strobe never falls on the first busy cycle (setup comes first)
    p_setup_first_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(busy));

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int DATA_W    = DATA_W_DEF,
    parameter int IORDY_SMP = IORDY_SMP_DEF,
    parameter int IORDY_LIM = IORDY_LIM_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_is_reg,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cfg_load,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_act8,
    input  logic [CNT_W-1:0]  cfg_cyc8,
    input  logic [CNT_W-1:0]  cfg_rec8,
    input  logic [CNT_W-1:0]  cfg_act16,
    input  logic [CNT_W-1:0]  cfg_cyc16,
    input  logic [CNT_W-1:0]  cfg_rec16,
    input  logic              cfg_iordy_en,
    input  logic              iordy,
    input  logic [DATA_W-1:0] bus_din,
    output logic [BSEL_W-1:0] bus_sel,
    output logic              dior_n,
    output logic              diow_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              iordy_timeout
);

    tset_t              sel_set;
    cnt_t               sel_setup;
    logic               sel_en;
    logic               capture;
    logic               tmo_pulse;
    logic               accept;
    logic [SEL_W-1:0]   sel_q;
    logic [DATA_W-1:0]  wdata_q;
    tset_t              reg_in;
    tset_t              dat_in;

    assign reg_in = '{act: cfg_act8,  cyc: cfg_cyc8,  rec: cfg_rec8};
    assign dat_in = '{act: cfg_act16, cyc: cfg_cyc16, rec: cfg_rec16};
    assign accept = req_valid && !busy;

    ata_pio_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (cfg_load),
        .setup_in  (cfg_setup),
        .reg_in    (reg_in),
        .dat_in    (dat_in),
        .en_in     (cfg_iordy_en),
        .is_reg    (req_is_reg),
        .set_out   (sel_set),
        .setup_out (sel_setup),
        .en_out    (sel_en)
    );

    ata_pio_phase_ctl #(
        .IORDY_SMP (IORDY_SMP),
        .IORDY_LIM (IORDY_LIM)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .is_write  (req_write),
        .set_in    (sel_set),
        .setup_in  (sel_setup),
        .en_in     (sel_en),
        .iordy     (iordy),
        .rd_n      (dior_n),
        .wr_n      (diow_n),
        .den       (bus_dout_en),
        .busy      (busy),
        .done      (done),
        .capture   (capture),
        .tmo_pulse (tmo_pulse)
    );

    ata_pio_bus_map u_map (
        .active  (busy),
        .sel     (sel_q),
        .bus_sel (bus_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q         <= '0;
            wdata_q       <= '0;
            rdata         <= '0;
            iordy_timeout <= 1'b0;
        end else begin
            if (accept) begin
                sel_q   <= req_sel;
                wdata_q <= req_wdata;
            end
            if (capture)
                rdata <= bus_din;
            if (tmo_pulse)
                iordy_timeout <= 1'b1;
        end
    end

    assign bus_dout = wdata_q;

    // R1: idle lines rest high
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bus_sel[1:0] == 2'b11) && dior_n && diow_n);

    // R4: write word holds while the write strobe is low
    p_dout_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!diow_n && $past(!diow_n)) |-> $stable(bus_dout));

    // R9: timeout flag is sticky
    p_timeout_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        iordy_timeout |=> iordy_timeout);

    // R10: select holds for the whole cycle
    p_sel_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(bus_sel));

endmodule

// File: tb/sim_ata_pio_seq.sv
module sim_ata_pio_seq;

    localparam int DW  = 16;
    localparam int SMP = 2;
    localparam int LIM = 65;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_is_reg;
    logic [3:0]  req_sel;
    logic [15:0] req_wdata;
    logic        cfg_load;
    logic [7:0]  cfg_setup, cfg_act8, cfg_cyc8, cfg_rec8, cfg_act16, cfg_cyc16, cfg_rec16;
    logic        cfg_iordy_en;
    logic        iordy;
    logic [15:0] bus_din;
    logic [4:0]  bus_sel;
    logic        dior_n, diow_n, bus_dout_en, busy, done, iordy_timeout;
    logic [15:0] bus_dout, rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit tmo_model = 0;

    always #10 clk = ~clk;

    ata_pio_seq #(.DATA_W(DW), .IORDY_SMP(SMP), .IORDY_LIM(LIM)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_is_reg(req_is_reg), .req_sel(req_sel), .req_wdata(req_wdata),
        .cfg_load(cfg_load), .cfg_setup(cfg_setup), .cfg_act8(cfg_act8),
        .cfg_cyc8(cfg_cyc8), .cfg_rec8(cfg_rec8), .cfg_act16(cfg_act16),
        .cfg_cyc16(cfg_cyc16), .cfg_rec16(cfg_rec16), .cfg_iordy_en(cfg_iordy_en),
        .iordy(iordy), .bus_din(bus_din), .bus_sel(bus_sel), .dior_n(dior_n),
        .diow_n(diow_n), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .busy(busy), .done(done), .rdata(rdata), .iordy_timeout(iordy_timeout)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int one_min(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic load_cfg(input int su, input int a8, input int c8, input int r8,
                            input int a16, input int c16, input int r16, input bit en);
        @(negedge clk);
        cfg_setup = 8'(su); cfg_act8 = 8'(a8); cfg_cyc8 = 8'(c8); cfg_rec8 = 8'(r8);
        cfg_act16 = 8'(a16); cfg_cyc16 = 8'(c16); cfg_rec16 = 8'(r16);
        cfg_iordy_en = en; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Cycle-by-cycle reference: t counts edges after the accepting edge.
    task automatic run_txn(input string ctx, input bit wr, input bit isreg, input logic [3:0] sel,
                           input logic [15:0] wd, input int su, input int act, input int cyc,
                           input int rec, input bit en, input int hi_at, input bit spam);
        int s, a, k, r, total;
        logic [4:0]  enc;
        logic [15:0] good;
        bit          rdy_hit;
        s = one_min(su);
        a = one_min(act);
        k = a - 1;
        if (en) begin
            while (!((k >= SMP && k >= hi_at) || k >= LIM - 1)) k++;
            rdy_hit = (k >= SMP && k >= hi_at);
            if (!rdy_hit) tmo_model = 1;
        end
        if (cyc > k + 1 && (cyc - (k + 1)) > one_min(rec)) r = cyc - (k + 1);
        else r = one_min(rec);
        total = s + k + 1 + r;
        enc = sel[3] ? 5'b110_01 : {sel[2:0], 2'b10};
        good = 16'h5A00 ^ {8'h00, 4'h0, sel};

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_is_reg = isreg; req_sel = sel; req_wdata = wd;
        iordy = 1'b0;
        for (int t = 0; t <= total; t++) begin
            @(negedge clk);
            // stray requests while busy (R10)
            req_valid = spam && (t < total);
            req_write = ~wr; req_sel = ~sel; req_wdata = ~wd; req_is_reg = ~isreg;
            iordy   = (t >= s + hi_at);
            bus_din = (t == s + k) ? good : ~good;
            chk({"R10 busy ", ctx}, 32'(busy), 32'(t < total));
            chk({"R10 done ", ctx}, 32'(done), 32'(t == total));
            chk({"R2 bus_sel ", ctx}, 32'(bus_sel), 32'((t < total) ? enc : 5'b000_11));
            chk({"R3 dior_n ", ctx}, 32'(dior_n), 32'(!(!wr && t >= s && t <= s + k)));
            chk({"R3 diow_n ", ctx}, 32'(diow_n), 32'(!(wr && t >= s && t <= s + k)));
            chk({"R4 dout_en ", ctx}, 32'(bus_dout_en), 32'(wr && t >= s && t <= s + k));
            if (wr && t >= s && t <= s + k)
                chk({"R4 dout ", ctx}, 32'(bus_dout), 32'(wd));
        end
        if (!wr) chk({"R5 rdata ", ctx}, 32'(rdata), 32'(good));
        chk({"R9 timeout ", ctx}, 32'(iordy_timeout), 32'(tmo_model));
        req_valid = 1'b0;
        iordy = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        n_fail++; n_chk++;
        $display("FAIL R10 watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 0; req_write = 0; req_is_reg = 0; req_sel = 0; req_wdata = 0;
        cfg_load = 0; cfg_setup = 0; cfg_act8 = 0; cfg_cyc8 = 0; cfg_rec8 = 0;
        cfg_act16 = 0; cfg_cyc16 = 0; cfg_rec16 = 0; cfg_iordy_en = 0; iordy = 1; bus_din = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 bus_sel", 32'(bus_sel), 32'h03);
        chk("R1 strobes", 32'({dior_n, diow_n}), 32'h3);
        chk("R1 flags", 32'({busy, done, iordy_timeout}), 32'h0);

        // R1 / R6: default register set, status read (idx 7)
        run_txn("R1 default reg read", 0, 1, 4'h7, 16'h0, 4, 15, 30, 15, 0, 0, 0);
        // R6: default data set
        run_txn("R6 default data write", 1, 0, 4'h0, 16'hBEEF, 4, 9, 30, 4, 0, 0, 0);

        load_cfg(2, 3, 12, 2, 5, 6, 3, 0);
        // R8 leftover path, iordy low is ignored with check off (R7), stray requests (R10)
        run_txn("R8 leftover write", 1, 1, 4'h2, 16'h1234, 2, 3, 12, 2, 0, 100, 1);
        // R8 minimum path on data set (R6)
        run_txn("R8 min data read", 0, 0, 4'h0, 16'h0, 2, 5, 6, 3, 0, 100, 0);
        // R2 control block register
        run_txn("R2 ctl write", 1, 1, 4'hE, 16'h0004, 2, 3, 12, 2, 0, 0, 1);

        // R11 zero counts
        load_cfg(0, 0, 0, 0, 0, 0, 0, 0);
        run_txn("R11 zero reg read", 0, 1, 4'h1, 16'h0, 0, 0, 0, 0, 0, 0, 0);
        run_txn("R11 zero data write", 1, 0, 4'h0, 16'hA5A5, 0, 0, 0, 0, 0, 0, 0);

        // R7 ready stretch
        load_cfg(1, 1, 10, 2, 1, 10, 2, 1);
        run_txn("R7 ready late", 0, 1, 4'h3, 16'h0, 1, 1, 10, 2, 1, 6, 0);
        run_txn("R7 ready early", 1, 1, 4'h4, 16'h7777, 1, 1, 10, 2, 1, 0, 0);
        // R9 timeout then sticky
        run_txn("R9 ready never", 0, 1, 4'h5, 16'h0, 1, 1, 10, 2, 1, 1000, 0);
        run_txn("R9 sticky after", 0, 0, 4'h0, 16'h0, 1, 1, 10, 2, 1, 0, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule